// File: doc/BRIEF.md
# In-order open-row SDRAM command scheduler

This block turns a stream of memory requests into DDR3-style commands for one rank with eight banks. Each request names a bank, a row, a starting column, a direction and a length in bytes. The block takes one request at a time and handles it to completion before it looks at the next one. Each request is kept inside a single row of a single bank, so one activation serves the whole request. It then issues the data commands for that request back to back, as fast as the burst spacing allows.

Each bank keeps its row open after use. A request to that same row goes straight to the data commands. A request to another row first closes the bank and then opens the new row. Every timing rule is a module parameter and is tracked by a small down-counter, either per bank or shared by all banks. A command is issued in the first cycle in which all of its counters have run out. Refresh, the data path and the PHY are not part of this block.

Top module: `sdram_fcfs_sched`

## Requirements
- R1: At most one command is issued per cycle, marked by `cmd_valid`, with `cmd_kind` 0 = ACT, 1 = PRE, 2 = RD, 3 = WR. `cmd_bank` and `cmd_row` carry the request's bank and row, and `cmd_col` carries the column of the current data command.
- R2: A request whose row is already open in its bank issues no PRE and no ACT. If another row is open, the block issues PRE and then ACT. If the bank is closed, it issues ACT only.
- R3: A request issues `req_len / 16` data commands (16 bytes per command, a 16-bit interface with burst length 8). The first uses `req_col` and each following one adds 8 to the column.
- R4: Requests are served strictly in arrival order. `req_ready` is low from the cycle after acceptance until the request ends. `done` is high for exactly the cycle after the last data command, and `req_ready` is high again in that same cycle.
- R5: An ACT and a data command to the same bank are at least tRCD = 6 cycles apart.
- R6: PRE to ACT in a bank is at least tRP = 6 cycles. ACT to PRE in a bank is at least tRAS = 15 cycles.
- R7: Data commands are at least tBURST = 4 cycles apart, both within a request and across requests.
- R8: PRE follows a read to that bank by at least tRTP = 4 cycles. PRE follows a write to that bank by at least tWL + 4 + tWR = 15 cycles.
- R9: A write follows a read by at least 7 cycles (tRL + 4 + 2 - tWL). A read follows a write by at least tWL + 4 + tWTR = 13 cycles.
- R10: Each command is issued in the first cycle in which every one of its constraints above is met. A request's first command can appear no earlier than the cycle after it is accepted.
- R11: After reset, all banks are closed, `req_ready` is high, and `cmd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_bank | input | 3 | Target bank |
| req_row | input | 14 | Target row |
| req_col | input | 10 | Starting column |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_len | input | 12 | Length in bytes, a nonzero multiple of 16 |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | 0 ACT, 1 PRE, 2 RD, 3 WR |
| cmd_bank | output | 3 | Command bank |
| cmd_row | output | 14 | Command row |
| cmd_col | output | 10 | Command column |
| done | output | 1 | One-cycle pulse after a request's last data command |

## Verification
A request accepted at one clock edge can produce its first command no earlier than the next cycle. Every later command is due exactly the binding timing distance after the command that constrains it, and `done` is due exactly one cycle after the last data command. The bench therefore records the cycle number of each command. It compares the gap to the previous command (or to acceptance, for the very first command) against a hand-computed table, and it checks `done` against the cycle of the last data command. All outputs are sampled 6 ns after the rising edge, and inputs are driven 1 ns after it.

// File: rtl/sdram_fcfs_sched.sv
module sdram_fcfs_sched #(
  parameter int NBANK   = 8,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int LEN_W   = 12,
  parameter int DQ_W    = 16,
  parameter int T_RCD   = 6,
  parameter int T_RP    = 6,
  parameter int T_RAS   = 15,
  parameter int T_RTP   = 4,
  parameter int T_WR    = 6,
  parameter int T_RL    = 6,
  parameter int T_WL    = 5,
  parameter int T_BURST = 4,
  parameter int T_WTR   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(NBANK)-1:0] req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  input  logic                     req_wr,
  input  logic [LEN_W-1:0]         req_len,
  output logic                     cmd_valid,
  output logic [1:0]               cmd_kind,
  output logic [$clog2(NBANK)-1:0] cmd_bank,
  output logic [ROW_W-1:0]         cmd_row,
  output logic [COL_W-1:0]         cmd_col,
  output logic                     done
);
  localparam int BA_W   = $clog2(NBANK);
  localparam int SHIFT  = $clog2(DQ_W * 8 / 8);
  localparam int WR_PRE = T_WL + T_BURST + T_WR;
  localparam int WR_RD  = T_WL + T_BURST + T_WTR;
  localparam int RD_WR  = T_RL + T_BURST + 2 - T_WL;
  localparam int TW     = 8;

  logic             busy, cur_wr, done_q;
  logic [BA_W-1:0]  cur_bank;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [LEN_W-1:0] left;
  logic             open_q   [NBANK];
  logic [ROW_W-1:0] open_row [NBANK];
  logic [TW-1:0]    t_rcd [NBANK];
  logic [TW-1:0]    t_rp  [NBANK];
  logic [TW-1:0]    t_ras [NBANK];
  logic [TW-1:0]    t_pre [NBANK];
  logic [TW-1:0]    t_ccd, t_rtw, t_wtr;

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  function automatic logic [TW-1:0] load(input logic [TW-1:0] c, input int t);
    logic [TW-1:0] d, n;
    d = dec(c);
    n = TW'(t - 1);
    return (d > n) ? d : n;
  endfunction

  logic hit, do_pre, do_act, do_cas, last;

  assign hit    = open_q[cur_bank] && (open_row[cur_bank] == cur_row);
  assign do_pre = busy && open_q[cur_bank] && !hit &&
                  t_ras[cur_bank] == '0 && t_pre[cur_bank] == '0;
  assign do_act = busy && !open_q[cur_bank] && t_rp[cur_bank] == '0;
  assign do_cas = busy && hit && t_rcd[cur_bank] == '0 && t_ccd == '0 &&
                  (cur_wr ? t_rtw == '0 : t_wtr == '0);
  assign last   = do_cas && left == LEN_W'(1);

  assign req_ready = !busy;
  assign cmd_valid = do_pre | do_act | do_cas;
  assign cmd_kind  = do_act ? 2'd0 : do_pre ? 2'd1 : {1'b1, cur_wr};
  assign cmd_bank  = cur_bank;
  assign cmd_row   = cur_row;
  assign cmd_col   = cur_col;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_wr   <= 1'b0;
      cur_bank <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
      left     <= '0;
      done_q   <= 1'b0;
      t_ccd    <= '0;
      t_rtw    <= '0;
      t_wtr    <= '0;
      for (int b = 0; b < NBANK; b++) begin
        open_q[b]   <= 1'b0;
        open_row[b] <= '0;
        t_rcd[b]    <= '0;
        t_rp[b]     <= '0;
        t_ras[b]    <= '0;
        t_pre[b]    <= '0;
      end
    end else begin
      done_q <= last;
      if (req_valid && !busy) begin
        busy     <= 1'b1;
        cur_bank <= req_bank;
        cur_row  <= req_row;
        cur_col  <= req_col;
        cur_wr   <= req_wr;
        left     <= req_len >> SHIFT;
      end
      if (do_cas) begin
        cur_col <= cur_col + COL_W'(8);
        left    <= left - 1'b1;
        if (last) busy <= 1'b0;
      end

      t_ccd <= do_cas ? load(t_ccd, T_BURST) : dec(t_ccd);
      t_rtw <= (do_cas && !cur_wr) ? load(t_rtw, RD_WR) : dec(t_rtw);
      t_wtr <= (do_cas &&  cur_wr) ? load(t_wtr, WR_RD) : dec(t_wtr);

      for (int b = 0; b < NBANK; b++) begin
        t_rcd[b] <= dec(t_rcd[b]);
        t_rp[b]  <= dec(t_rp[b]);
        t_ras[b] <= dec(t_ras[b]);
        t_pre[b] <= dec(t_pre[b]);
        if (cur_bank == BA_W'(b)) begin
          if (do_act) begin
            open_q[b]   <= 1'b1;
            open_row[b] <= cur_row;
            t_rcd[b]    <= load(t_rcd[b], T_RCD);
            t_ras[b]    <= load(t_ras[b], T_RAS);
          end
          if (do_pre) begin
            open_q[b] <= 1'b0;
            t_rp[b]   <= load(t_rp[b], T_RP);
          end
          if (do_cas)
            t_pre[b] <= load(t_pre[b], cur_wr ? WR_PRE : T_RTP);
        end
      end
    end
  end
endmodule

// File: rtl/sdram_fcfs_sched_chk.sv
module sdram_fcfs_sched_chk #(
  parameter int NBANK   = 8,
  parameter int T_RCD   = 6,
  parameter int T_RP    = 6,
  parameter int T_RAS   = 15,
  parameter int T_BURST = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_ready,
  input logic                     cmd_valid,
  input logic [1:0]               cmd_kind,
  input logic [$clog2(NBANK)-1:0] cmd_bank,
  input logic                     done
);
  localparam int AW = 8;
  localparam logic [AW-1:0] SAT = '1;

  logic [AW-1:0] act_age [NBANK];
  logic [AW-1:0] pre_age [NBANK];
  logic [AW-1:0] cas_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cas_age <= SAT;
      for (int b = 0; b < NBANK; b++) begin
        act_age[b] <= SAT;
        pre_age[b] <= SAT;
      end
    end else begin
      cas_age <= (cmd_valid && cmd_kind[1]) ? AW'(1) :
                 (cas_age == SAT ? SAT : cas_age + 1'b1);
      for (int b = 0; b < NBANK; b++) begin
        act_age[b] <= (cmd_valid && cmd_kind == 2'd0 && int'(cmd_bank) == b) ? AW'(1) :
                      (act_age[b] == SAT ? SAT : act_age[b] + 1'b1);
        pre_age[b] <= (cmd_valid && cmd_kind == 2'd1 && int'(cmd_bank) == b) ? AW'(1) :
                      (pre_age[b] == SAT ? SAT : pre_age[b] + 1'b1);
      end
    end
  end

  a_r5_act_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind[1] |-> act_age[cmd_bank] >= AW'(T_RCD));
  a_r6_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd0 |-> pre_age[cmd_bank] >= AW'(T_RP));
  a_r6_act_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd1 |-> act_age[cmd_bank] >= AW'(T_RAS));
  a_r7_cas_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind[1] |-> cas_age >= AW'(T_BURST));
  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);
  a_r4_done_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && $past(cmd_valid && cmd_kind[1]));
endmodule

bind sdram_fcfs_sched sdram_fcfs_sched_chk #(
  .NBANK(NBANK), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_BURST(T_BURST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .done(done)
);

// File: tb/sdram_fcfs_sched_test.sv
module sdram_fcfs_sched_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [2:0] req_bank = '0;
  logic [13:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic [11:0] req_len = '0;
  logic req_ready, cmd_valid, done;
  logic [1:0] cmd_kind;
  logic [2:0] cmd_bank;
  logic [13:0] cmd_row;
  logic [9:0] cmd_col;

  always #5 clk = ~clk;

  sdram_fcfs_sched uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wr(req_wr),
    .req_len(req_len), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .done(done)
  );

  localparam int NREQ = 10;
  localparam int NCMD = 27;
  // {bank, row, col, wr, len}
  localparam logic [39:0] STIM [NREQ] = '{
    {3'd0, 14'd5, 10'd0,  1'b0, 12'd64},
    {3'd0, 14'd5, 10'd32, 1'b0, 12'd32},
    {3'd0, 14'd5, 10'd64, 1'b1, 12'd16},
    {3'd0, 14'd9, 10'd0,  1'b0, 12'd16},
    {3'd3, 14'd2, 10'd16, 1'b1, 12'd32},
    {3'd3, 14'd2, 10'd0,  1'b0, 12'd16},
    {3'd5, 14'd1, 10'd0,  1'b0, 12'd16},
    {3'd5, 14'd7, 10'd0,  1'b0, 12'd16},
    {3'd5, 14'd7, 10'd8,  1'b0, 12'd64},
    {3'd5, 14'd3, 10'd0,  1'b0, 12'd16}
  };
  // {kind, bank, row, col, gap, tag}; gap counts cycles from the previous command
  localparam logic [40:0] EXP [NCMD] = '{
    {2'd0, 3'd0, 14'd5, 10'd0,  8'd1,  4'd2},  // R2 R10 closed bank: ACT only
    {2'd2, 3'd0, 14'd5, 10'd0,  8'd6,  4'd5},  // R5
    {2'd2, 3'd0, 14'd5, 10'd8,  8'd4,  4'd7},  // R7
    {2'd2, 3'd0, 14'd5, 10'd16, 8'd4,  4'd3},  // R3
    {2'd2, 3'd0, 14'd5, 10'd24, 8'd4,  4'd7},  // R7
    {2'd2, 3'd0, 14'd5, 10'd32, 8'd4,  4'd2},  // R2 row hit, R7 across requests
    {2'd2, 3'd0, 14'd5, 10'd40, 8'd4,  4'd3},  // R3
    {2'd3, 3'd0, 14'd5, 10'd64, 8'd7,  4'd9},  // R9 read to write
    {2'd1, 3'd0, 14'd9, 10'd0,  8'd15, 4'd8},  // R8 write to PRE
    {2'd0, 3'd0, 14'd9, 10'd0,  8'd6,  4'd6},  // R6 tRP
    {2'd2, 3'd0, 14'd9, 10'd0,  8'd6,  4'd5},  // R5
    {2'd0, 3'd3, 14'd2, 10'd16, 8'd2,  4'd4},  // R4 next request in order
    {2'd3, 3'd3, 14'd2, 10'd16, 8'd6,  4'd5},  // R5
    {2'd3, 3'd3, 14'd2, 10'd24, 8'd4,  4'd7},  // R7
    {2'd2, 3'd3, 14'd2, 10'd0,  8'd13, 4'd9},  // R9 write to read
    {2'd0, 3'd5, 14'd1, 10'd0,  8'd2,  4'd2},  // R2
    {2'd2, 3'd5, 14'd1, 10'd0,  8'd6,  4'd5},  // R5
    {2'd1, 3'd5, 14'd7, 10'd0,  8'd9,  4'd6},  // R6 tRAS
    {2'd0, 3'd5, 14'd7, 10'd0,  8'd6,  4'd6},  // R6
    {2'd2, 3'd5, 14'd7, 10'd0,  8'd6,  4'd5},  // R5
    {2'd2, 3'd5, 14'd7, 10'd8,  8'd4,  4'd2},  // R2
    {2'd2, 3'd5, 14'd7, 10'd16, 8'd4,  4'd3},  // R3
    {2'd2, 3'd5, 14'd7, 10'd24, 8'd4,  4'd7},  // R7
    {2'd2, 3'd5, 14'd7, 10'd32, 8'd4,  4'd3},  // R3
    {2'd1, 3'd5, 14'd3, 10'd0,  8'd4,  4'd8},  // R8 read to PRE
    {2'd0, 3'd5, 14'd3, 10'd0,  8'd6,  4'd6},  // R6
    {2'd2, 3'd5, 14'd3, 10'd0,  8'd6,  4'd5}   // R5 R1 fields
  };

  int cyc = 0, checks = 0, fails = 0;
  int ncmd = 0, ndone = 0, acc_slot = 0, last_slot = 0;
  logic last_cas = 1'b0, was_acc = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #6;
    if (rst_n) begin
      if (was_acc) check(req_ready == 1'b0, "R4 ready low after accept", req_ready, 0);
      was_acc = req_valid && req_ready;
      if (was_acc) acc_slot = cyc;
      if (cmd_valid) begin
        if (ncmd < NCMD) begin
          logic [40:0] e;
          int gap;
          e = EXP[ncmd];
          gap = (ncmd == 0) ? cyc - acc_slot : cyc - last_slot;
          check({cmd_kind, cmd_bank, cmd_row, cmd_col} == e[40:12],
                $sformatf("R%0d R1 cmd %0d fields {kind,bank,row,col}", e[3:0], ncmd),
                {cmd_kind, cmd_bank, cmd_row, cmd_col}, e[40:12]);
          check(gap == int'(e[11:4]),
                $sformatf("R%0d R10 cmd %0d gap", e[3:0], ncmd), gap, e[11:4]);
        end else check(1'b0, "R3 extra command", ncmd, NCMD - 1);
        ncmd++;
        last_slot = cyc;
        last_cas = cmd_kind[1];
      end
      if (done) begin
        ndone++;
        check(last_cas && cyc - last_slot == 1, "R4 done one cycle after last CAS",
              cyc - last_slot, 1);
        check(req_ready == 1'b1, "R4 ready with done", req_ready, 1);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #6;
    check(req_ready == 1'b1, "R11 ready in reset", req_ready, 1);
    check(cmd_valid == 1'b0, "R11 no command in reset", cmd_valid, 0);
    check(done == 1'b0, "R11 done low in reset", done, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #6;
    check(cmd_valid == 1'b0 && req_ready == 1'b1, "R11 idle after reset",
          {cmd_valid, req_ready}, 1);
    for (int i = 0; i < NREQ; i++) begin
      forever begin
        @(posedge clk);
        #1;
        if (req_ready) break;
      end
      {req_bank, req_row, req_col, req_wr, req_len} = STIM[i];
      req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
    end
    while (ndone < NREQ && cyc < 3000) @(posedge clk);
    repeat (3) @(posedge clk);
    #6;
    check(ncmd == NCMD, "R3 total commands", ncmd, NCMD);
    check(ndone == NREQ, "R4 total done pulses", ndone, NREQ);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 3000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule